// File: doc/BRIEF.md
# Cascadable Dual Reload Timer

This block holds two 8-bit up-counters that advance once every two system clock cycles, through a shared divide-by-two prescaler. When a counter passes its top value it reloads from a preset byte of its own, sets an overflow flag and, if that timer's interrupt enable bit is set, raises an interrupt request. A three-bit mode field runs either timer alone, both independently, or chains them into one 16-bit reload timer in which the first counter is the low byte and the second counter is the high byte.

Software reaches the block through a simple write port: a strobe, a two-bit address and a data byte, with address 0 the mode field, 1 the low preset, 2 the high preset and 3 the interrupt enables. The two overflow flags are visible on a status port at all times, and a read strobe clears both of them, so that a polling loop sees each overflow once.

Top module: `dual_reload_timer`

## Requirements
- R1: A synchronous active-high reset clears the mode field, presets, interrupt enables, both flags and both interrupt requests; with mode 000 no flag is ever set.
- R2: An enabled counter advances once every second clock cycle; with a preset P written before the mode, the first overflow flag is seen 2*(256-P) clock edges after the edge that writes the mode field.
- R3: On overflow the counter reloads from its preset, so further overflows follow every 2*(256-P) clock edges.
- R4: Mode field (address 0, bits 2:0): 000 stops both timers, bit 0 runs the low timer, bit 1 runs the high timer, bit 2 set chains them and overrides bits 1:0.
- R5: In chained mode the 16-bit value {high, low} counts up from {P_high, P_low}; a low-byte wrap below the top goes to zero and carries into the high byte; the 16-bit overflow occurs every 2*(65536-{P_high,P_low}) edges, reloads both bytes and sets only status bit 1.
- R6: Writing a preset while a timer runs leaves the current count alone; the new value is used from the next reload.
- R7: Status bit 0 is the low-timer flag and bit 1 the high-timer flag; the read strobe shows the flags in its own cycle and clears both at that clock edge.
- R8: If a read strobe and a new overflow fall on the same edge, that timer's flag stays set.
- R9: Interrupt request bit i equals flag i AND enable bit i, with the enables at address 3 bits 1:0 (bit 0 low timer, bit 1 high timer).
- R10: A stopped timer sits at its preset and sets no flag; when started it counts from the preset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 mode, 1 low preset, 2 high preset, 3 interrupt enables |
| wr_data | input | 8 | Write data |
| rd_stb | input | 1 | Status read strobe, clears the flags |
| status | output | 2 | Overflow flags: bit 0 low timer, bit 1 high timer |
| irq | output | 2 | Interrupt requests, one per timer |

## Verification
The clearing read and a fresh overflow can land on the same clock edge, and the outcome decides whether an overflow is lost. A directed case counts edges from the mode write to the known overflow edge and raises the read strobe exactly there, expecting the flag to survive; random traffic then fires read strobes at random phases against running timers, and every cycle the flags and requests are compared with a cycle model built from the requirements.

// File: rtl/drt_pkg.sv
package drt_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned N_TMR   = 2;
  localparam int unsigned ADDR_W  = 2;
  localparam int unsigned MODE_W  = 3;

  localparam logic [ADDR_W-1:0] A_MODE = 2'd0;
  localparam logic [ADDR_W-1:0] A_PLO  = 2'd1;
  localparam logic [ADDR_W-1:0] A_PHI  = 2'd2;
  localparam logic [ADDR_W-1:0] A_IEN  = 2'd3;

  typedef struct packed {
    logic chain;
    logic run_hi;
    logic run_lo;
  } mode_t;
endpackage

// File: rtl/drt_prescale.sv
module drt_prescale (
  input  logic clk,
  input  logic rst,
  input  logic active,
  output logic tick
);
  logic phase_q;

  always_ff @(posedge clk) begin
    if (rst)          phase_q <= 1'b0;
    else if (active)  phase_q <= ~phase_q;
    else              phase_q <= 1'b0;
  end

  assign tick = active & phase_q;

  // R2: ticks never come back to back
  a_r2_tick_alternates: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/drt_counter.sv
module drt_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         step,
  input  logic         reload_ok,
  input  logic [W-1:0] preset,
  output logic         at_top,
  output logic         wrap
);
  localparam logic [W-1:0] TOP = {W{1'b1}};
  logic [W-1:0] cnt_q;

  assign at_top = (cnt_q == TOP);
  assign wrap   = run & step & at_top;

  always_ff @(posedge clk) begin
    if (rst)           cnt_q <= '0;
    else if (!run)     cnt_q <= preset;
    else if (step) begin
      if (at_top)      cnt_q <= reload_ok ? preset : '0;
      else             cnt_q <= cnt_q + 1'b1;
    end
  end

  // R2: a running counter holds between steps
  a_r2_hold_between_steps: assert property (@(posedge clk) disable iff (rst)
    (run && !step) |=> (cnt_q == $past(cnt_q)));
  // R3: a wrap that may reload lands on the preset
  a_r3_reload_value: assert property (@(posedge clk) disable iff (rst)
    (wrap && reload_ok) |=> (cnt_q == $past(preset)));
endmodule

// File: rtl/drt_flags.sv
module drt_flags #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic [N-1:0] ovf,
  input  logic [N-1:0] ien_next,
  output logic [N-1:0] flag,
  output logic [N-1:0] req
);
  logic [N-1:0] flag_q, req_q;
  logic [N-1:0] flag_n;

  assign flag_n = (clr ? '0 : flag_q) | ovf;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
      req_q  <= '0;
    end else begin
      flag_q <= flag_n;
      req_q  <= flag_n & ien_next;
    end
  end

  assign flag = flag_q;
  assign req  = req_q;

  generate
    for (genvar i = 0; i < N; i++) begin : g_chk
      // R8: an overflow on the clearing edge survives
      a_r8_ovf_wins: assert property (@(posedge clk) disable iff (rst)
        ovf[i] |=> flag_q[i]);
      // R9: request only with its flag
      a_r9_req_needs_flag: assert property (@(posedge clk) disable iff (rst)
        req_q[i] |-> flag_q[i]);
    end
  endgenerate

  // R7: a read with no new overflow empties the flags
  a_r7_read_clears: assert property (@(posedge clk) disable iff (rst)
    (clr && (ovf == '0)) |=> (flag_q == '0));
endmodule

// File: rtl/dual_reload_timer.sv
module dual_reload_timer
  import drt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              rd_stb,
  output logic [N_TMR-1:0]  status,
  output logic [N_TMR-1:0]  irq
);
  mode_t              mode_q;
  logic [BYTE_W-1:0]  preset_q [N_TMR];
  logic [N_TMR-1:0]   ien_q, ien_n;

  // register writes
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      ien_q  <= '0;
    end else if (wr_en) begin
      if (wr_addr == A_MODE) mode_q <= mode_t'(wr_data[MODE_W-1:0]);
      if (wr_addr == A_IEN)  ien_q  <= wr_data[N_TMR-1:0];
    end
  end

  generate
    for (genvar i = 0; i < N_TMR; i++) begin : g_pre
      localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(i + 1);
      always_ff @(posedge clk) begin
        if (rst)                               preset_q[i] <= '0;
        else if (wr_en && wr_addr == MY_ADDR)  preset_q[i] <= wr_data;
      end
    end
  endgenerate

  assign ien_n = (wr_en && wr_addr == A_IEN) ? wr_data[N_TMR-1:0] : ien_q;

  // timer control
  logic run_lo, run_hi, active, tick;
  logic lo_top, hi_top, lo_wrap, hi_wrap;
  logic [N_TMR-1:0] ovf;

  assign run_lo = mode_q.chain | mode_q.run_lo;
  assign run_hi = mode_q.chain | mode_q.run_hi;
  assign active = run_lo | run_hi;

  drt_prescale u_pre (
    .clk    (clk),
    .rst    (rst),
    .active (active),
    .tick   (tick)
  );

  drt_counter #(.W(BYTE_W)) u_lo (
    .clk       (clk),
    .rst       (rst),
    .run       (run_lo),
    .step      (tick),
    .reload_ok (~mode_q.chain | hi_top),
    .preset    (preset_q[0]),
    .at_top    (lo_top),
    .wrap      (lo_wrap)
  );

  drt_counter #(.W(BYTE_W)) u_hi (
    .clk       (clk),
    .rst       (rst),
    .run       (run_hi),
    .step      (mode_q.chain ? (tick & lo_top) : tick),
    .reload_ok (1'b1),
    .preset    (preset_q[1]),
    .at_top    (hi_top),
    .wrap      (hi_wrap)
  );

  assign ovf = {hi_wrap, lo_wrap & ~mode_q.chain};

  drt_flags #(.N(N_TMR)) u_flags (
    .clk      (clk),
    .rst      (rst),
    .clr      (rd_stb),
    .ovf      (ovf),
    .ien_next (ien_n),
    .flag     (status),
    .req      (irq)
  );

  // R1: flags are empty right after reset
  a_r1_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (status == '0 && irq == '0));
  // R4: a stopped block raises no overflow
  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !active |-> (ovf == '0));
  // R5: chained mode never flags the low timer
  a_r5_chain_no_lo_flag: assert property (@(posedge clk) disable iff (rst)
    mode_q.chain |-> !ovf[0]);
endmodule

// File: tb/dual_reload_timer_tb_top.sv
module dual_reload_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       rd_stb = 1'b0;
  logic [1:0] status, irq;

  int n_run = 0;
  int n_fail = 0;
  string phase = "R1";

  always #4 clk = ~clk;

  dual_reload_timer dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_stb(rd_stb), .status(status), .irq(irq)
  );

  // reference model from the requirements
  logic [2:0] m_mode;
  logic [7:0] m_p0, m_p1, m_c0, m_c1;
  logic [1:0] m_ien, m_flag, m_irq;
  logic       m_ph;
  always @(posedge clk) begin
    logic tk, any, o0, o1;
    logic [15:0] v;
    if (rst) begin
      m_mode = 0; m_p0 = 0; m_p1 = 0; m_c0 = 0; m_c1 = 0;
      m_ien = 0; m_flag = 0; m_irq = 0; m_ph = 0;
    end else begin
      any = (m_mode != 3'b000);
      tk = any && m_ph;
      o0 = 0; o1 = 0;
      if (m_mode[2]) begin
        v = {m_c1, m_c0};
        if (tk) begin
          if (v == 16'hFFFF) begin v = {m_p1, m_p0}; o1 = 1; end
          else v = v + 16'd1;
        end
        {m_c1, m_c0} = v;
      end else begin
        if (!m_mode[0]) m_c0 = m_p0;
        else if (tk) begin
          if (m_c0 == 8'hFF) begin m_c0 = m_p0; o0 = 1; end else m_c0 = m_c0 + 8'd1;
        end
        if (!m_mode[1]) m_c1 = m_p1;
        else if (tk) begin
          if (m_c1 == 8'hFF) begin m_c1 = m_p1; o1 = 1; end else m_c1 = m_c1 + 8'd1;
        end
      end
      m_ph = any ? ~m_ph : 1'b0;
      m_flag = (rd_stb ? 2'b00 : m_flag) | {o1, o0};
      if (wr_en) begin
        case (wr_addr)
          2'd0: m_mode = wr_data[2:0];
          2'd1: m_p0 = wr_data;
          2'd2: m_p1 = wr_data;
          default: m_ien = wr_data[1:0];
        endcase
      end
      m_irq = m_flag & m_ien;
    end
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // one clock, then compare outputs with the model
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    check({phase, " status"}, {6'd0, status}, {6'd0, m_flag});
    check({phase, " irq"}, {6'd0, irq}, {6'd0, m_irq});
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step(); step();
    rst = 1'b0;
  endtask

  task automatic wait_flag(input int b, input int lim, output int n);
    n = 0;
    while (status[b] !== 1'b1 && n < lim) begin step(); n++; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int n, seed;
    @(negedge clk);
    do_reset();
    // R1: reset state
    phase = "R1";
    check("R1 status after reset", {6'd0, status}, 8'd0);
    check("R1 irq after reset", {6'd0, irq}, 8'd0);
    repeat (600) step();
    check("R1 no flag while stopped", {6'd0, status}, 8'd0);

    // R2 / R3: first and repeat period, low timer
    phase = "R2";
    wr(2'd1, 8'hF0);
    wr(2'd0, 8'h01);
    wait_flag(0, 2000, n);
    check("R2 first overflow edge count", 8'(n), 8'd32);
    rd_stb = 1'b1; step(); rd_stb = 1'b0;
    phase = "R3";
    wait_flag(0, 2000, n);
    check("R3 reload period", 8'(n + 1), 8'd32);
    check("R4 low-only mode leaves high flag", {7'd0, status[1]}, 8'd0);

    // R10 / R4: high timer alone, low stays stopped
    do_reset();
    phase = "R10";
    wr(2'd2, 8'hFD);
    wr(2'd0, 8'h02);
    wait_flag(1, 2000, n);
    check("R10 high starts from preset", 8'(n), 8'd6);
    repeat (40) step();
    check("R10 stopped low timer no flag", {7'd0, status[0]}, 8'd0);

    // R7: read shows then clears
    phase = "R7";
    rd_stb = 1'b1;
    #1 check("R7 flag visible during read", {7'd0, status[1]}, 8'd1);
    step(); rd_stb = 1'b0;
    check("R7 flags cleared after read", {6'd0, status}, 8'd0);

    // R8: read on the overflow edge
    do_reset();
    phase = "R8";
    wr(2'd1, 8'hFC);
    wr(2'd0, 8'h01);
    repeat (7) step();
    check("R8 no flag before edge", {7'd0, status[0]}, 8'd0);
    rd_stb = 1'b1; step(); rd_stb = 1'b0;
    check("R8 overflow beats read", {7'd0, status[0]}, 8'd1);

    // R6: preset write during count
    do_reset();
    phase = "R6";
    wr(2'd1, 8'hF0);
    wr(2'd0, 8'h01);
    repeat (10) step();
    wr(2'd1, 8'hFC);
    wait_flag(0, 2000, n);
    check("R6 running count undisturbed", 8'(n + 11), 8'd32);
    rd_stb = 1'b1; step(); rd_stb = 1'b0;
    wait_flag(0, 2000, n);
    check("R6 new preset at next reload", 8'(n + 1), 8'd8);

    // R5: chained 16-bit with low byte through zero
    do_reset();
    phase = "R5";
    wr(2'd1, 8'hF0);
    wr(2'd2, 8'hFE);
    wr(2'd0, 8'h07);
    wait_flag(1, 5000, n);
    check("R5 chained period", {6'd0, n[9:8]}, 8'd2);
    check("R5 chained period low", 8'(n), 8'h20);
    check("R5 chained low flag clear", {7'd0, status[0]}, 8'd0);

    // R9: request gating
    do_reset();
    phase = "R9";
    wr(2'd3, 8'h01);
    wr(2'd1, 8'hFC);
    wr(2'd2, 8'hFE);
    wr(2'd0, 8'h03);
    repeat (10) step();
    check("R9 status both", {6'd0, status}, 8'd3);
    check("R9 irq gated", {6'd0, irq}, 8'd1);
    wr(2'd3, 8'h02);
    check("R9 irq after enable change", {6'd0, irq}, 8'd2);

    // random traffic against the model
    do_reset();
    phase = "R4 random";
    seed = $urandom(32'd20240611);
    for (int k = 0; k < 6000; k++) begin
      logic [31:0] r;
      r = $urandom;
      rd_stb = (r[1:0] == 2'b00);
      if (r[6:4] == 3'b000) begin
        wr_en = 1'b1; wr_addr = r[9:8];
        wr_data = (r[9:8] == 2'd1 || r[9:8] == 2'd2) ? {4'hF, r[15:12]} : r[23:16];
      end
      step();
      wr_en = 1'b0; rd_stb = 1'b0;
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule